// File: doc/BRIEF.md
# Multi-Device Serial EEPROM Fetch Controller

This block pulls a byte stream out of serial EEPROMs by driving a byte-level I2C master. It issues start, repeated start, write-byte, read-byte and stop commands. It does not handle bit timing on the wire. It starts fetching on its own once reset is released. Each byte it reads goes to a downstream consumer over a valid/ready handshake. That consumer is typically a frame parser that decodes configuration records.

Two addressing modes are chosen by a static mode pin:

- **Paged mode** walks up to eight small devices in turn. Each device is selected by a 3-bit chip-enable field in the device address byte. The controller moves from one device to the next with a repeated start and never releases the bus between devices.
- **Wide mode** reads a single device that has a two-byte word address.

Fetching ends when the consumer reports, on the handshake of a byte, that the final frame is complete. If the read would instead wrap back to the first address, the controller releases the bus and halts with an error. It does the same if a device does not acknowledge its address.

Top module: `eef_fetch`

## Requirements
- R1: After reset the first command is a start (`cmd_op` 0), followed by a write (`cmd_op` 2) of the device byte. The device byte is {4-bit `DEV_CODE` (default 4'b1010), 3-bit chip enable, R/W bit}, with chip enable 0 and R/W 0. During reset `out_valid`, `done` and `error` are low.
- R2: Each device access writes word address 0 as one zero byte in paged mode and two zero bytes in wide mode. A repeated start (`cmd_op` 1) then follows, then the device byte with R/W 1.
- R3: Bytes are delivered once each and in address order. `out_data` is held stable while `out_valid` is high and `out_ready` is low. No command is issued while a byte waits for the consumer.
- R4: Each read command (`cmd_op` 3) sets `cmd_nack` to 1 exactly when it reads the last byte of a device's range: byte `STD_SPAN`-1 in paged mode, byte `EXT_SPAN`-1 in wide mode. For every other byte `cmd_nack` is 0.
- R5: In paged mode, after the last byte of a device is consumed and the final frame has not been seen, the next chip enable is addressed through a repeated start. No stop and no new start is issued, so a whole run has exactly one start.
- R6: A handshake with `final_frame` high leads to a stop command (`cmd_op` 4). `done` then rises and stays high, and no further command is issued.
- R7: If the last byte of the last device in paged mode, or the last byte in wide mode, is consumed without `final_frame`, the block issues a stop and raises `error`. It issues nothing further.
- R8: A device that answers its address byte with a NACK (`rsp_nack` 1) causes a stop followed by `error`.
- R9: `done` and `error` are never high together, and each stays high until reset.
- R10: A command is held unchanged while `cmd_valid` is high and `cmd_ready` is low. A new command is issued only after the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0: paged multi-device mode, 1: wide single-device mode |
| cmd_valid | output | 1 | Command offered to the byte-level I2C master |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_op | output | 3 | 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 stop |
| cmd_wdata | output | 8 | Byte to write |
| cmd_nack | output | 1 | For a read: 1 = answer the byte with NACK |
| rsp_valid | input | 1 | One-cycle completion of the accepted command |
| rsp_data | input | 8 | Byte read |
| rsp_nack | input | 1 | Device did not acknowledge the written byte |
| out_valid | output | 1 | Fetched byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Fetched byte |
| final_frame | input | 1 | Qualified by the byte handshake: final frame complete |
| done | output | 1 | Fetch finished normally |
| error | output | 1 | Wrap-around or address NACK |

## Verification
The bench builds the block with three paged devices of 8 bytes each and a wide span of 40 bytes. With these sizes, device hand-over, the NACK on each range end and the wrap-around error are all reached within a few dozen bytes, on both modes, in one short run. A bench EEPROM model with only two devices present makes the third chip enable answer with a NACK, which exercises the address-NACK path. Random ready patterns on both the command and consumer sides stress the hold behaviour.

// File: rtl/eef_pkg.sv
package eef_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        ST_START, ST_DEVW, ST_WAH, ST_WAL, ST_RST, ST_RSTW,
        ST_DEVR, ST_READ, ST_HOLD, ST_STOP, ST_DONE, ST_ERR
    } st_e;

    typedef struct packed {
        logic       valid;
        op_e        op;
        logic [7:0] wdata;
        logic       nack;
    } cmd_t;

    function automatic logic [7:0] dev_byte(input logic [3:0] code,
                                            input logic [2:0] ce,
                                            input logic rd);
        return {code, ce, rd};
    endfunction

endpackage

// File: rtl/eef_addr_track.sv
module eef_addr_track
    import eef_pkg::*;
#(
    parameter int STD_DEVS = 8,
    parameter int STD_SPAN = 256,
    parameter int EXT_SPAN = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic              step,
    output logic [2:0]        ce,
    output logic [ADDR_W-1:0] addr,
    output logic              last_in_dev,
    output logic              last_dev
);
    localparam logic [ADDR_W-1:0] STD_LAST = ADDR_W'(STD_SPAN - 1);
    localparam logic [ADDR_W-1:0] EXT_LAST = ADDR_W'(EXT_SPAN - 1);
    localparam logic [2:0]        CE_LAST  = 3'(STD_DEVS - 1);

    always_comb begin
        last_in_dev = ext_mode ? (addr == EXT_LAST) : (addr == STD_LAST);
        last_dev    = ext_mode || (ce == CE_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ce   <= '0;
            addr <= '0;
        end else if (step) begin
            if (last_in_dev && !ext_mode && !last_dev) begin
                addr <= '0;
                ce   <= ce + 3'd1;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    // R5: paged mode restarts the byte address at a fresh chip enable
    a_r5_dev_step: assert property (@(posedge clk) disable iff (rst)
        step && last_in_dev && !ext_mode && !last_dev |=> addr == '0 && ce == $past(ce) + 3'd1);

endmodule

// File: rtl/eef_seq.sv
module eef_seq
    import eef_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_mode,
    input  logic [2:0] ce,
    input  logic       last_in_dev,
    input  logic       last_dev,
    output logic       step,
    output logic       cmd_valid,
    input  logic       cmd_ready,
    output logic [2:0] cmd_op,
    output logic [7:0] cmd_wdata,
    output logic       cmd_nack,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_data,
    input  logic       rsp_nack,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    input  logic       final_frame,
    output logic       done,
    output logic       error
);
    st_e        st;
    logic       waiting;
    logic       fail;
    logic [7:0] hold_q;
    cmd_t       cmd;

    always_comb begin
        cmd = '{valid: 1'b0, op: OP_STOP, wdata: 8'h00, nack: 1'b0};
        unique case (st)
            ST_START:        cmd = '{valid: 1'b1, op: OP_START,   wdata: 8'h00, nack: 1'b0};
            ST_DEVW:         cmd = '{valid: 1'b1, op: OP_WRITE,   wdata: dev_byte(DEV_CODE, ce, 1'b0), nack: 1'b0};
            ST_WAH, ST_WAL:  cmd = '{valid: 1'b1, op: OP_WRITE,   wdata: 8'h00, nack: 1'b0};
            ST_RST, ST_RSTW: cmd = '{valid: 1'b1, op: OP_RESTART, wdata: 8'h00, nack: 1'b0};
            ST_DEVR:         cmd = '{valid: 1'b1, op: OP_WRITE,   wdata: dev_byte(DEV_CODE, ce, 1'b1), nack: 1'b0};
            ST_READ:         cmd = '{valid: 1'b1, op: OP_READ,    wdata: 8'h00, nack: last_in_dev};
            ST_STOP:         cmd = '{valid: 1'b1, op: OP_STOP,    wdata: 8'h00, nack: 1'b0};
            default:         ;
        endcase
    end

    assign cmd_valid = cmd.valid && !waiting;
    assign cmd_op    = cmd.op;
    assign cmd_wdata = cmd.wdata;
    assign cmd_nack  = cmd.nack;
    assign out_valid = (st == ST_HOLD);
    assign out_data  = hold_q;
    assign done      = (st == ST_DONE);
    assign error     = (st == ST_ERR);
    assign step      = (st == ST_HOLD) && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_START;
            waiting <= 1'b0;
            fail    <= 1'b0;
            hold_q  <= 8'h00;
        end else if (st == ST_HOLD) begin
            if (out_ready) begin
                if (final_frame) begin
                    st <= ST_STOP;
                end else if (last_in_dev && last_dev) begin
                    st   <= ST_STOP;
                    fail <= 1'b1;
                end else if (last_in_dev) begin
                    st <= ST_RSTW;
                end else begin
                    st <= ST_READ;
                end
            end
        end else if (cmd_valid && cmd_ready) begin
            waiting <= 1'b1;
        end else if (waiting && rsp_valid) begin
            waiting <= 1'b0;
            unique case (st)
                ST_START, ST_RSTW: st <= ST_DEVW;
                ST_DEVW: begin
                    if (rsp_nack) begin
                        st   <= ST_STOP;
                        fail <= 1'b1;
                    end else begin
                        st <= ext_mode ? ST_WAH : ST_WAL;
                    end
                end
                ST_WAH: st <= ST_WAL;
                ST_WAL: st <= ST_RST;
                ST_RST: st <= ST_DEVR;
                ST_DEVR: begin
                    if (rsp_nack) begin
                        st   <= ST_STOP;
                        fail <= 1'b1;
                    end else begin
                        st <= ST_READ;
                    end
                end
                ST_READ: begin
                    hold_q <= rsp_data;
                    st     <= ST_HOLD;
                end
                ST_STOP: st <= fail ? ST_ERR : ST_DONE;
                default: ;
            endcase
        end
    end

    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_nack));
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_valid);
    a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r3_no_cmd_while_byte: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !cmd_valid);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && error));
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    a_r9_error_sticky: assert property (@(posedge clk) disable iff (rst)
        error |=> error);
    a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !cmd_valid && !out_valid);
    a_r6_final_stops: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && final_frame |=> cmd_valid && cmd_op == 3'(OP_STOP));

endmodule

// File: rtl/eef_fetch.sv
module eef_fetch
    import eef_pkg::*;
#(
    parameter int         STD_DEVS = 8,
    parameter int         STD_SPAN = 256,
    parameter int         EXT_SPAN = 65536,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_mode,
    output logic       cmd_valid,
    input  logic       cmd_ready,
    output logic [2:0] cmd_op,
    output logic [7:0] cmd_wdata,
    output logic       cmd_nack,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_data,
    input  logic       rsp_nack,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    input  logic       final_frame,
    output logic       done,
    output logic       error
);
    logic [2:0]        ce;
    logic [ADDR_W-1:0] addr;
    logic              last_in_dev;
    logic              last_dev;
    logic              step;

    eef_addr_track #(
        .STD_DEVS(STD_DEVS), .STD_SPAN(STD_SPAN), .EXT_SPAN(EXT_SPAN)
    ) u_track (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .step(step),
        .ce(ce), .addr(addr), .last_in_dev(last_in_dev), .last_dev(last_dev)
    );

    eef_seq #(.DEV_CODE(DEV_CODE)) u_seq (
        .clk(clk), .rst(rst), .ext_mode(ext_mode),
        .ce(ce), .last_in_dev(last_in_dev), .last_dev(last_dev), .step(step),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .final_frame(final_frame), .done(done), .error(error)
    );

endmodule

// File: tb/eef_fetch_bench.sv
module eef_fetch_bench;
    localparam int NDEV = 3;
    localparam int SPAN = 8;
    localparam int XSPAN = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_mode = 1'b0;
    logic cmd_valid, cmd_ready, cmd_nack;
    logic [2:0] cmd_op;
    logic [7:0] cmd_wdata;
    logic rsp_valid, rsp_nack;
    logic [7:0] rsp_data;
    logic out_valid, out_ready, final_frame, done, error;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    eef_fetch #(.STD_DEVS(NDEV), .STD_SPAN(SPAN), .EXT_SPAN(XSPAN)) u_eef_fetch (
        .clk(clk), .rst(rst), .ext_mode(ext_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .final_frame(final_frame), .done(done), .error(error)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int ce, input int a);
        return 8'((ce * 83 + a * 29 + (a >> 5) * 7 + 17) & 255);
    endfunction

    // model state
    bit   m_ext;
    int   present_n, final_at;
    bit   pend, expect_dev, first_cmd, stopped;
    logic [2:0] p_op;
    logic [7:0] p_wd;
    logic p_nk;
    int   cur_ce, ptr, wa_cnt, rx;
    int   start_cnt, stop_cnt, after_stop;
    bit   prev_wait;
    logic [7:0] prev_data;

    initial begin
        cmd_ready = 0; rsp_valid = 0; rsp_data = 0; rsp_nack = 0;
        out_ready = 0; final_frame = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                cmd_ready = 0; rsp_valid = 0; rsp_nack = 0; pend = 0;
                out_ready = 0; final_frame = 0; prev_wait = 0;
                continue;
            end
            // command side
            if (rsp_valid) begin rsp_valid = 0; rsp_nack = 0; end
            if (pend) begin
                pend = 0; cmd_ready = 0; rsp_valid = 1; rsp_nack = 0;
                if (first_cmd) begin
                    chk(p_op == 3'd0, "R1 first command is start", int'(p_op), 0);
                    first_cmd = 0;
                end
                if (stopped) after_stop++;
                case (p_op)
                    3'd0: begin start_cnt++; expect_dev = 1; end
                    3'd1: expect_dev = 1;
                    3'd2: begin
                        if (expect_dev) begin
                            expect_dev = 0;
                            chk(p_wd[7:4] == 4'b1010, "R1 device code", int'(p_wd[7:4]), 10);
                            if (!p_wd[0]) begin
                                cur_ce = int'(p_wd[3:1]);
                                chk(cur_ce == (m_ext ? 0 : rx / SPAN), "R5 chip enable", cur_ce,
                                    m_ext ? 0 : rx / SPAN);
                                wa_cnt = 0; ptr = 0;
                            end else begin
                                chk(int'(p_wd[3:1]) == cur_ce, "R2 read device matches", int'(p_wd[3:1]), cur_ce);
                                chk(wa_cnt == (m_ext ? 2 : 1), "R2 word address length", wa_cnt, m_ext ? 2 : 1);
                            end
                            rsp_nack = (int'(p_wd[3:1]) >= present_n);
                        end else begin
                            chk(p_wd == 8'h00, "R2 word address zero", int'(p_wd), 0);
                            wa_cnt++;
                            ptr = ((ptr << 8) | int'(p_wd)) & 16'hFFFF;
                        end
                    end
                    3'd3: begin
                        chk(p_nk == (ptr == (m_ext ? XSPAN : SPAN) - 1), "R4 read ack/nack",
                            int'(p_nk), int'(ptr == (m_ext ? XSPAN : SPAN) - 1));
                        rsp_data = pat(cur_ce, ptr);
                        ptr++;
                    end
                    3'd4: begin stop_cnt++; stopped = 1; end
                    default: chk(0, "R10 legal opcode", int'(p_op), 4);
                endcase
            end else begin
                cmd_ready = ($urandom % 3) != 0;
                if (cmd_valid && cmd_ready) begin
                    pend = 1; p_op = cmd_op; p_wd = cmd_wdata; p_nk = cmd_nack;
                end
            end
            // consumer side
            if (prev_wait)
                chk(out_valid && out_data == prev_data, "R3 byte held while not ready",
                    int'(out_data), int'(prev_data));
            if (out_valid)
                chk(!cmd_valid, "R3 no command while byte waits", int'(cmd_valid), 0);
            out_ready = ($urandom % 4) != 0;
            final_frame = 0;
            if (out_valid && out_ready) begin
                chk(out_data == (m_ext ? pat(0, rx) : pat(rx / SPAN, rx % SPAN)), "R3 byte order/value",
                    int'(out_data), int'(m_ext ? pat(0, rx) : pat(rx / SPAN, rx % SPAN)));
                final_frame = (rx == final_at);
                rx++;
            end
            prev_wait = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    task automatic run(input bit ext, input int fin, input int present,
                       input bit exp_err, input int exp_bytes, input string tag);
        int cyc;
        @(negedge clk);
        rst = 1; ext_mode = ext; m_ext = ext; final_at = fin; present_n = present;
        first_cmd = 1; stopped = 0; expect_dev = 0; cur_ce = 0; ptr = 0; wa_cnt = 0; rx = 0;
        start_cnt = 0; stop_cnt = 0; after_stop = 0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && !error, "R1 reset state", int'({out_valid, done, error}), 0);
        rst = 0;
        cyc = 0;
        while (!(done || error) && cyc < 6000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 6000, {tag, " watchdog"}, cyc, 6000);
        repeat (20) @(negedge clk);
        if (exp_err)
            chk(error && !done, {tag, " R7/R8 error raised, R9 exclusive"}, int'({done, error}), 1);
        else
            chk(done && !error, {tag, " R6 done raised, R9 exclusive"}, int'({done, error}), 2);
        chk(rx == exp_bytes, {tag, " byte count"}, rx, exp_bytes);
        chk(stop_cnt == 1, {tag, " R6 single stop"}, stop_cnt, 1);
        chk(start_cnt == 1, {tag, " R5 single start, repeated starts between devices"}, start_cnt, 1);
        chk(after_stop == 0, {tag, " R6 nothing after stop"}, after_stop, 0);
    endtask

    initial begin
        int f;
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        run(0, 5, NDEV, 0, 6, "R6 paged final in first device");
        run(0, SPAN + 3, NDEV, 0, SPAN + 4, "R5 paged final after device change");
        run(0, -1, NDEV, 1, NDEV * SPAN, "R7 paged wrap");
        run(1, 20, 1, 0, 21, "R2 wide final");
        run(1, -1, 1, 1, XSPAN, "R7 wide wrap");
        run(0, -1, 2, 1, 2 * SPAN, "R8 address nack");
        run(0, 0, NDEV, 0, 1, "R6 final on first byte");
        run(0, NDEV * SPAN - 1, NDEV, 0, NDEV * SPAN, "R7 final on very last byte");
        for (int i = 0; i < 4; i++) begin
            f = int'($urandom % (NDEV * SPAN));
            run(0, f, NDEV, 0, f + 1, "R3 random paged final");
            f = int'($urandom % XSPAN);
            run(1, f, 1, 0, f + 1, "R3 random wide final");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule